// File: doc/BRIEF.md
# Multi-bank OUT endpoint receive buffer

This block holds host-to-device packets for a single bulk or interrupt OUT endpoint in one, two or three packet banks. A packet source marks the start of each packet, streams its bytes, and then marks the end together with a good or bad verdict. A good packet that found a free bank is committed and acknowledged. A packet that starts while every configured bank is holding unread data is refused and not stored.

The consumer sees a receive-ready flag and the byte count of the bank it is currently accessing. It also sees that bank's index, the number of busy banks and an all-banks-busy flag. It pulls bytes out through a read port. Banks fill and drain in strict round-robin order. In manual mode the consumer hands a bank back with an explicit clear. In auto-validate mode hardware hands the bank back as soon as its last byte has been read. A zero-length packet is also handed back at once in auto-validate mode, so it never stays visible.

The bank count is taken from a configuration input while the endpoint is disabled. Disabling the endpoint empties every bank.

Top module: `out_ep_bank_buf`

## Requirements
- R1: A good packet that started while the write bank was free produces a one-cycle `pkt_ack_o` pulse on the cycle after its end. From that cycle on, `rx_ready_o` is 1 and `byte_cnt_o` equals the number of bytes received.
- R2: When `rx_clear_i` is high while `rx_ready_o` is 1, the current bank is released and `cur_bank_o` advances. When `rx_ready_o` is 0, `rx_clear_i` changes nothing.
- R3: Each `rd_en_i` on a ready bank returns the next stored byte in arrival order on `rd_data_o`, with `rd_vld_o` high, one cycle later. A read beyond the byte count gives `rd_vld_o` = 0.
- R4: With `auto_valid_i` = 1, the bank is released with no clear on the same edge that returns its last byte.
- R5: A good zero-length packet into a free bank is acknowledged and raises `rx_ready_o` with `byte_cnt_o` = 0. Reading it gives no valid byte.
- R6: With `auto_valid_i` = 1, a zero-length packet's ready state lasts one cycle and is then released by hardware.
- R7: `all_busy_o` is 1 exactly when the busy-bank count equals the configured bank count. A packet starting then gets a `pkt_nak_o` pulse on the next cycle, no acknowledge, and is not stored.
- R8: Packets are written to banks 0,1,..,N-1 in turn and wrap to 0. `cur_bank_o` advances in the same order as banks are released.
- R9: `nb_banks_i` (1, 2 or 3; 0 means 1) is taken only while `ep_en_i` = 0. Changes while enabled have no effect. Dropping `ep_en_i` empties all banks and returns both bank pointers to 0.
- R10: Bytes beyond 512 in one packet are dropped, and the byte count stops at 512.
- R11: A packet ending with `pkt_good_i` = 0 is discarded: no acknowledge, and the bank stays free.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ep_en_i | input | 1 | Endpoint enable; low flushes and loads the bank count |
| nb_banks_i | input | 2 | Configured bank count (0 or 1 = one bank) |
| auto_valid_i | input | 1 | 1 = hardware releases a bank once it is fully read |
| pkt_start_i | input | 1 | Start of an incoming packet |
| pkt_data_vld_i | input | 1 | Byte strobe for pkt_data_i |
| pkt_data_i | input | 8 | Packet byte |
| pkt_end_i | input | 1 | End of packet |
| pkt_good_i | input | 1 | Packet verdict, sampled with pkt_end_i |
| pkt_ack_o | output | 1 | Packet stored (one-cycle pulse) |
| pkt_nak_o | output | 1 | Packet refused, no free bank (one-cycle pulse) |
| rd_en_i | input | 1 | Read one byte from the current bank |
| rx_clear_i | input | 1 | Release the current bank |
| rd_data_o | output | 8 | Read byte |
| rd_vld_o | output | 1 | rd_data_o is valid |
| rx_ready_o | output | 1 | Current bank holds a received packet |
| byte_cnt_o | output | 10 | Byte count of the current bank |
| cur_bank_o | output | 2 | Index of the bank the consumer is accessing |
| busy_cnt_o | output | 2 | Number of busy banks |
| all_busy_o | output | 1 | Every configured bank is busy |

## Verification
The assertions check several relations on every cycle. The busy count never exceeds the configured bank count. Acknowledge and refusal never coincide, and an acknowledge always leaves at least one bank busy. A start while all banks are busy is always refused. A clear on a ready bank lowers the busy count by one, net of any packet committed on the same edge. A read byte never appears without a read request. Only the directed scenarios can show the rest: byte order and content, round-robin bank order, the 512-byte saturation, the one-cycle life of an auto-validated zero-length packet, and the rule that the bank count is taken only while the endpoint is disabled.

// File: rtl/out_ep_pkg.sv
package out_ep_pkg;

  typedef enum logic {
    FILL_IDLE = 1'b0,
    FILL_RECV = 1'b1
  } fill_state_e;

  // round-robin successor of idx among n banks
  function automatic int unsigned wrap_inc(int unsigned idx, int unsigned n);
    return (idx + 1 >= n) ? 0 : idx + 1;
  endfunction

  function automatic int unsigned clamp_banks(int unsigned raw, int unsigned max_n);
    if (raw == 0) return 1;
    if (raw > max_n) return max_n;
    return raw;
  endfunction

endpackage

// File: rtl/out_ep_bank_ram.sv
module out_ep_bank_ram #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DEPTH  = 512,
  localparam int unsigned AW    = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [AW-1:0]     waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              re_i,
  input  logic [AW-1:0]     raddr_i,
  output logic [DATA_W-1:0] rdata_o
);

  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
    if (re_i) rdata_o <= mem_q[raddr_i];
  end

endmodule

// File: rtl/out_ep_rx_fill.sv
module out_ep_rx_fill
  import out_ep_pkg::*;
#(
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned MAX_PKT = 512,
  parameter int unsigned BANK_W  = 2,
  localparam int unsigned ADDR_W = $clog2(MAX_PKT),
  localparam int unsigned CNT_W  = $clog2(MAX_PKT + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ep_en_i,
  input  logic [BANK_W-1:0] nb_i,
  input  logic              bank_free_i,
  input  logic              start_i,
  input  logic              data_vld_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              end_i,
  input  logic              good_i,
  output logic              wr_en_o,
  output logic [BANK_W-1:0] wr_bank_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic              commit_o,
  output logic [CNT_W-1:0]  commit_cnt_o,
  output logic              ack_o,
  output logic              nak_o
);

  fill_state_e       st_q;
  logic [BANK_W-1:0] bank_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [CNT_W-1:0]  cnt_nxt;
  logic              recv;

  assign recv         = (st_q == FILL_RECV);
  assign wr_en_o      = recv && data_vld_i && (cnt_q < CNT_W'(MAX_PKT));
  assign cnt_nxt      = cnt_q + CNT_W'(wr_en_o);
  assign wr_bank_o    = bank_q;
  assign wr_addr_o    = cnt_q[ADDR_W-1:0];
  assign wr_data_o    = data_i;
  assign commit_o     = ep_en_i && recv && !start_i && end_i && good_i;
  assign commit_cnt_o = cnt_nxt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= FILL_IDLE;
      bank_q <= '0;
      cnt_q  <= '0;
      ack_o  <= 1'b0;
      nak_o  <= 1'b0;
    end else if (!ep_en_i) begin
      st_q   <= FILL_IDLE;
      bank_q <= '0;
      cnt_q  <= '0;
      ack_o  <= 1'b0;
      nak_o  <= 1'b0;
    end else begin
      ack_o <= commit_o;
      nak_o <= start_i && !bank_free_i;
      if (start_i) begin
        st_q  <= bank_free_i ? FILL_RECV : FILL_IDLE;
        cnt_q <= '0;
      end else if (recv) begin
        cnt_q <= cnt_nxt;
        if (end_i) begin
          st_q <= FILL_IDLE;
          if (good_i) bank_q <= BANK_W'(wrap_inc(32'(bank_q), 32'(nb_i)));
        end
      end
    end
  end

endmodule

// File: rtl/out_ep_bank_state.sv
module out_ep_bank_state
  import out_ep_pkg::*;
#(
  parameter int unsigned MAX_BANKS = 3,
  parameter int unsigned MAX_PKT   = 512,
  parameter int unsigned BANK_W    = 2,
  localparam int unsigned CNT_W    = $clog2(MAX_PKT + 1)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 ep_en_i,
  input  logic [BANK_W-1:0]    nb_i,
  input  logic                 auto_i,
  input  logic                 commit_i,
  input  logic [BANK_W-1:0]    commit_bank_i,
  input  logic [CNT_W-1:0]     commit_cnt_i,
  input  logic                 rd_en_i,
  input  logic                 clear_i,
  output logic [MAX_BANKS-1:0] full_o,
  output logic [BANK_W-1:0]    cur_o,
  output logic [CNT_W-1:0]     rptr_o,
  output logic                 rd_fire_o,
  output logic                 rx_ready_o,
  output logic [CNT_W-1:0]     byte_cnt_o,
  output logic [BANK_W-1:0]    busy_cnt_o,
  output logic                 all_busy_o
);

  logic             full_q [MAX_BANKS];
  logic [CNT_W-1:0] cnt_q  [MAX_BANKS];
  logic [BANK_W-1:0] cur_q;
  logic [CNT_W-1:0] rptr_q;
  logic [CNT_W-1:0] cur_cnt;
  logic             last_rd;
  logic             release_w;

  assign cur_cnt    = cnt_q[cur_q];
  assign rx_ready_o = full_q[cur_q];
  assign byte_cnt_o = rx_ready_o ? cur_cnt : '0;
  assign rd_fire_o  = rx_ready_o && rd_en_i && (rptr_q < cur_cnt);
  assign last_rd    = rd_fire_o && ((rptr_q + CNT_W'(1)) == cur_cnt);
  // zero-length bank in auto mode goes back on the cycle after it lands
  assign release_w  = rx_ready_o &&
                      (clear_i || (auto_i && (last_rd || cur_cnt == '0)));
  assign cur_o      = cur_q;
  assign rptr_o     = rptr_q;

  for (genvar g = 0; g < MAX_BANKS; g++) begin : g_bank
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        full_q[g] <= 1'b0;
        cnt_q[g]  <= '0;
      end else if (!ep_en_i) begin
        full_q[g] <= 1'b0;
        cnt_q[g]  <= '0;
      end else if (commit_i && commit_bank_i == BANK_W'(g)) begin
        full_q[g] <= 1'b1;
        cnt_q[g]  <= commit_cnt_i;
      end else if (release_w && cur_q == BANK_W'(g)) begin
        full_q[g] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_q  <= '0;
      rptr_q <= '0;
    end else if (!ep_en_i) begin
      cur_q  <= '0;
      rptr_q <= '0;
    end else if (release_w) begin
      cur_q  <= BANK_W'(wrap_inc(32'(cur_q), 32'(nb_i)));
      rptr_q <= '0;
    end else if (rd_fire_o) begin
      rptr_q <= rptr_q + CNT_W'(1);
    end
  end

  always_comb begin
    busy_cnt_o = '0;
    for (int i = 0; i < MAX_BANKS; i++) begin
      full_o[i]  = full_q[i];
      busy_cnt_o = busy_cnt_o + BANK_W'(full_q[i]);
    end
  end

  assign all_busy_o = (busy_cnt_o == nb_i);

endmodule

// File: rtl/out_ep_bank_buf.sv
module out_ep_bank_buf
  import out_ep_pkg::*;
#(
  parameter int unsigned MAX_BANKS = 3,
  parameter int unsigned MAX_PKT   = 512,
  parameter int unsigned DATA_W    = 8,
  localparam int unsigned BANK_W   = $clog2(MAX_BANKS + 1),
  localparam int unsigned ADDR_W   = $clog2(MAX_PKT),
  localparam int unsigned CNT_W    = $clog2(MAX_PKT + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ep_en_i,
  input  logic [BANK_W-1:0] nb_banks_i,
  input  logic              auto_valid_i,
  input  logic              pkt_start_i,
  input  logic              pkt_data_vld_i,
  input  logic [DATA_W-1:0] pkt_data_i,
  input  logic              pkt_end_i,
  input  logic              pkt_good_i,
  output logic              pkt_ack_o,
  output logic              pkt_nak_o,
  input  logic              rd_en_i,
  input  logic              rx_clear_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rd_vld_o,
  output logic              rx_ready_o,
  output logic [CNT_W-1:0]  byte_cnt_o,
  output logic [BANK_W-1:0] cur_bank_o,
  output logic [BANK_W-1:0] busy_cnt_o,
  output logic              all_busy_o
);

  logic [BANK_W-1:0]    nb_q;
  logic [MAX_BANKS-1:0] full;
  logic                 wr_en;
  logic [BANK_W-1:0]    wr_bank;
  logic [ADDR_W-1:0]    wr_addr;
  logic [DATA_W-1:0]    wr_data;
  logic                 commit;
  logic [CNT_W-1:0]     commit_cnt;
  logic [CNT_W-1:0]     rptr;
  logic                 rd_fire;
  logic [BANK_W-1:0]    rd_sel_q;
  logic [DATA_W-1:0]    ram_q [MAX_BANKS];

  // bank count only follows the input while the endpoint is off
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       nb_q <= BANK_W'(1);
    else if (!ep_en_i) nb_q <= BANK_W'(clamp_banks(32'(nb_banks_i), MAX_BANKS));
  end

  out_ep_rx_fill #(
    .DATA_W (DATA_W),
    .MAX_PKT(MAX_PKT),
    .BANK_W (BANK_W)
  ) u_fill (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ep_en_i     (ep_en_i),
    .nb_i        (nb_q),
    .bank_free_i (!full[wr_bank]),
    .start_i     (pkt_start_i),
    .data_vld_i  (pkt_data_vld_i),
    .data_i      (pkt_data_i),
    .end_i       (pkt_end_i),
    .good_i      (pkt_good_i),
    .wr_en_o     (wr_en),
    .wr_bank_o   (wr_bank),
    .wr_addr_o   (wr_addr),
    .wr_data_o   (wr_data),
    .commit_o    (commit),
    .commit_cnt_o(commit_cnt),
    .ack_o       (pkt_ack_o),
    .nak_o       (pkt_nak_o)
  );

  out_ep_bank_state #(
    .MAX_BANKS(MAX_BANKS),
    .MAX_PKT  (MAX_PKT),
    .BANK_W   (BANK_W)
  ) u_state (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .ep_en_i      (ep_en_i),
    .nb_i         (nb_q),
    .auto_i       (auto_valid_i),
    .commit_i     (commit),
    .commit_bank_i(wr_bank),
    .commit_cnt_i (commit_cnt),
    .rd_en_i      (rd_en_i),
    .clear_i      (rx_clear_i),
    .full_o       (full),
    .cur_o        (cur_bank_o),
    .rptr_o       (rptr),
    .rd_fire_o    (rd_fire),
    .rx_ready_o   (rx_ready_o),
    .byte_cnt_o   (byte_cnt_o),
    .busy_cnt_o   (busy_cnt_o),
    .all_busy_o   (all_busy_o)
  );

  for (genvar g = 0; g < MAX_BANKS; g++) begin : g_ram
    out_ep_bank_ram #(
      .DATA_W(DATA_W),
      .DEPTH (MAX_PKT)
    ) u_ram (
      .clk_i  (clk_i),
      .we_i   (wr_en && wr_bank == BANK_W'(g)),
      .waddr_i(wr_addr),
      .wdata_i(wr_data),
      .re_i   (rd_fire && cur_bank_o == BANK_W'(g)),
      .raddr_i(rptr[ADDR_W-1:0]),
      .rdata_o(ram_q[g])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_vld_o <= 1'b0;
      rd_sel_q <= '0;
    end else begin
      rd_vld_o <= rd_fire;
      if (rd_fire) rd_sel_q <= cur_bank_o;
    end
  end

  assign rd_data_o = ram_q[rd_sel_q];

endmodule

// File: rtl/out_ep_bank_buf_chk.sv
module out_ep_bank_buf_chk #(
  parameter int unsigned BANK_W = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ep_en_i,
  input logic              pkt_start_i,
  input logic              pkt_ack_o,
  input logic              pkt_nak_o,
  input logic              rd_en_i,
  input logic              rx_clear_i,
  input logic              rd_vld_o,
  input logic              rx_ready_o,
  input logic [BANK_W-1:0] busy_cnt_o,
  input logic              all_busy_o,
  input logic [BANK_W-1:0] nb_q
);

  p_busy_bound_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_cnt_o <= nb_q);

  p_ack_nak_excl_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(pkt_ack_o && pkt_nak_o));

  p_nak_when_full_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ep_en_i && pkt_start_i && all_busy_o) |=> pkt_nak_o);

  p_ack_leaves_busy_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pkt_ack_o |-> (busy_cnt_o != '0));

  p_clear_releases_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ep_en_i && rx_clear_i && rx_ready_o) |=>
      (({1'b0, busy_cnt_o} + 1'b1) == ({1'b0, $past(busy_cnt_o)} + {{BANK_W{1'b0}}, pkt_ack_o})));

  p_rd_needs_req_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_vld_o |-> $past(rd_en_i));

endmodule

bind out_ep_bank_buf out_ep_bank_buf_chk #(.BANK_W(BANK_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .ep_en_i    (ep_en_i),
  .pkt_start_i(pkt_start_i),
  .pkt_ack_o  (pkt_ack_o),
  .pkt_nak_o  (pkt_nak_o),
  .rd_en_i    (rd_en_i),
  .rx_clear_i (rx_clear_i),
  .rd_vld_o   (rd_vld_o),
  .rx_ready_o (rx_ready_o),
  .busy_cnt_o (busy_cnt_o),
  .all_busy_o (all_busy_o),
  .nb_q       (nb_q)
);

// File: tb/out_ep_bank_buf_tb.sv
`timescale 1ns/1ps
module out_ep_bank_buf_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ep_en = 1'b0;
  logic [1:0] nb_banks = 2'd2;
  logic       auto_v = 1'b0;
  logic       pkt_start = 1'b0, pkt_vld = 1'b0, pkt_end = 1'b0, pkt_good = 1'b0;
  logic [7:0] pkt_data = '0;
  logic       rd_en = 1'b0, rx_clear = 1'b0;
  logic       pkt_ack, pkt_nak, rd_vld, rx_ready, all_busy;
  logic [7:0] rd_data;
  logic [9:0] byte_cnt;
  logic [1:0] cur_bank, busy_cnt;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  out_ep_bank_buf u_dut (
    .clk_i(clk), .rst_ni(rst_n), .ep_en_i(ep_en), .nb_banks_i(nb_banks),
    .auto_valid_i(auto_v), .pkt_start_i(pkt_start), .pkt_data_vld_i(pkt_vld),
    .pkt_data_i(pkt_data), .pkt_end_i(pkt_end), .pkt_good_i(pkt_good),
    .pkt_ack_o(pkt_ack), .pkt_nak_o(pkt_nak), .rd_en_i(rd_en), .rx_clear_i(rx_clear),
    .rd_data_o(rd_data), .rd_vld_o(rd_vld), .rx_ready_o(rx_ready),
    .byte_cnt_o(byte_cnt), .cur_bank_o(cur_bank), .busy_cnt_o(busy_cnt),
    .all_busy_o(all_busy)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_eq(input string req, input int act, input int exp);
    chk(act == exp, req, act, exp);
  endtask

  // all tasks start and end on a falling edge
  task automatic send_pkt(input int n, input int base, input logic good,
                          output logic ack, output logic nak);
    ack = 1'b0; nak = 1'b0;
    pkt_start = 1'b1;
    @(negedge clk); pkt_start = 1'b0;
    nak |= pkt_nak; ack |= pkt_ack;
    for (int i = 0; i < n; i++) begin
      pkt_vld = 1'b1; pkt_data = 8'(base + i);
      @(negedge clk);
      nak |= pkt_nak;
    end
    pkt_vld = 1'b0; pkt_end = 1'b1; pkt_good = good;
    @(negedge clk);
    pkt_end = 1'b0; pkt_good = 1'b0;
    ack |= pkt_ack; nak |= pkt_nak;
  endtask

  task automatic read_byte(output logic vld, output logic [7:0] d);
    rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0;
    vld = rd_vld; d = rd_data;
  endtask

  task automatic read_block(input int n, input int base, input string req);
    logic v; logic [7:0] d; int bad = 0; int first_bad = 0;
    for (int i = 0; i < n; i++) begin
      read_byte(v, d);
      if (!v || d != 8'(base + i)) begin
        if (bad == 0) first_bad = i;
        bad++;
      end
    end
    chk_eq({req, " byte mismatches (first at ", $sformatf("%0d", first_bad), ")"}, bad, 0);
  endtask

  task automatic do_clear();
    rx_clear = 1'b1;
    @(negedge clk); rx_clear = 1'b0;
  endtask

  task automatic reconfig(input logic [1:0] nb);
    ep_en = 1'b0;
    @(negedge clk); nb_banks = nb;
    @(negedge clk); ep_en = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk_eq("reset rx_ready", int'(rx_ready), 0);
    chk_eq("reset busy_cnt", int'(busy_cnt), 0);
    chk_eq("reset all_busy", int'(all_busy), 0);
    chk_eq("reset cur_bank", int'(cur_bank), 0);
    chk_eq("reset ack/nak", int'(pkt_ack | pkt_nak), 0);
  endtask

  task automatic t_manual();
    logic a, n, v; logic [7:0] d;
    send_pkt(5, 8'h10, 1'b1, a, n);
    chk_eq("R1 ack", int'(a), 1);
    chk_eq("R1 rx_ready", int'(rx_ready), 1);
    chk_eq("R1 byte_cnt", int'(byte_cnt), 5);
    read_block(5, 8'h10, "R3 read order");
    read_byte(v, d);
    chk_eq("R3 read past count", int'(v), 0);
    chk_eq("R2 still ready before clear", int'(rx_ready), 1);
    do_clear();
    chk_eq("R2 ready after clear", int'(rx_ready), 0);
    chk_eq("R2 busy after clear", int'(busy_cnt), 0);
    chk_eq("R2 cur advanced", int'(cur_bank), 1);
    do_clear();
    chk_eq("R2 idle clear keeps cur", int'(cur_bank), 1);
    chk_eq("R2 idle clear keeps busy", int'(busy_cnt), 0);
  endtask

  task automatic t_round_robin();
    logic a, n;
    send_pkt(3, 8'h40, 1'b1, a, n);
    chk_eq("R8 first packet ack", int'(a), 1);
    chk_eq("R7 one of two busy", int'(all_busy), 0);
    send_pkt(4, 8'h80, 1'b1, a, n);
    chk_eq("R7 all_busy", int'(all_busy), 1);
    chk_eq("R7 busy_cnt", int'(busy_cnt), 2);
    send_pkt(6, 8'hC0, 1'b1, a, n);
    chk_eq("R7 nak when full", int'(n), 1);
    chk_eq("R7 no ack when full", int'(a), 0);
    chk_eq("R8 cur bank 1", int'(cur_bank), 1);
    chk_eq("R8 count bank 1", int'(byte_cnt), 3);
    read_block(3, 8'h40, "R8 bank 1 data");
    do_clear();
    chk_eq("R8 wrap to bank 0", int'(cur_bank), 0);
    chk_eq("R8 count bank 0", int'(byte_cnt), 4);
    read_block(4, 8'h80, "R8 bank 0 data");
    do_clear();
    chk_eq("R7 refused packet not stored", int'(busy_cnt), 0);
    chk_eq("R7 ready low", int'(rx_ready), 0);
  endtask

  task automatic t_auto();
    logic a, n;
    auto_v = 1'b1;
    send_pkt(3, 8'h21, 1'b1, a, n);
    read_block(2, 8'h21, "R4 partial read");
    chk_eq("R4 held until last byte", int'(rx_ready), 1);
    read_block(1, 8'h23, "R4 last byte");
    chk_eq("R4 released on last read", int'(rx_ready), 0);
    chk_eq("R4 busy after release", int'(busy_cnt), 0);
    chk_eq("R4 cur advanced", int'(cur_bank), 0);
    auto_v = 1'b0;
  endtask

  task automatic t_zlp();
    logic a, n, v; logic [7:0] d;
    send_pkt(0, 0, 1'b1, a, n);
    chk_eq("R5 zlp ack", int'(a), 1);
    chk_eq("R5 zlp ready", int'(rx_ready), 1);
    chk_eq("R5 zlp count", int'(byte_cnt), 0);
    read_byte(v, d);
    chk_eq("R5 zlp no data", int'(v), 0);
    do_clear();
    auto_v = 1'b1;
    send_pkt(0, 0, 1'b1, a, n);
    chk_eq("R6 auto zlp ack", int'(a), 1);
    chk_eq("R6 auto zlp ready one cycle", int'(rx_ready), 1);
    @(negedge clk);
    chk_eq("R6 auto zlp released", int'(rx_ready), 0);
    chk_eq("R6 auto zlp busy", int'(busy_cnt), 0);
    auto_v = 1'b0;
  endtask

  task automatic t_bad();
    logic a, n;
    send_pkt(3, 8'h55, 1'b0, a, n);
    chk_eq("R11 no ack", int'(a), 0);
    chk_eq("R11 bank free", int'(busy_cnt), 0);
    chk_eq("R11 ready low", int'(rx_ready), 0);
  endtask

  task automatic t_overflow();
    logic a, n, v; logic [7:0] d;
    send_pkt(520, 0, 1'b1, a, n);
    chk_eq("R10 ack", int'(a), 1);
    chk_eq("R10 saturated count", int'(byte_cnt), 512);
    read_block(512, 0, "R10 stored bytes");
    read_byte(v, d);
    chk_eq("R10 extra bytes dropped", int'(v), 0);
    do_clear();
  endtask

  task automatic t_bank_cfg();
    logic a, n;
    reconfig(2'd3);
    chk_eq("R9 flush cur", int'(cur_bank), 0);
    nb_banks = 2'd1;
    send_pkt(1, 1, 1'b1, a, n);
    send_pkt(1, 2, 1'b1, a, n);
    chk_eq("R9 enabled change ignored", int'(all_busy), 0);
    send_pkt(1, 3, 1'b1, a, n);
    chk_eq("R9 three banks all busy", int'(all_busy), 1);
    chk_eq("R9 three busy", int'(busy_cnt), 3);
    ep_en = 1'b0;
    @(negedge clk);
    chk_eq("R9 disable flushes", int'(busy_cnt), 0);
    nb_banks = 2'd0;
    @(negedge clk); ep_en = 1'b1;
    @(negedge clk);
    send_pkt(2, 9, 1'b1, a, n);
    chk_eq("R9 zero means one bank", int'(all_busy), 1);
    send_pkt(2, 9, 1'b1, a, n);
    chk_eq("R9 single bank nak", int'(n), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    ep_en = 1'b1;
    @(negedge clk);
    t_manual();
    t_round_robin();
    t_auto();
    t_zlp();
    t_bad();
    t_overflow();
    t_bank_cfg();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

endmodule